// File: doc/BRIEF.md
# Cumulative Overtemperature Assertion Timer

This block keeps a running total of how long an active-low thermal-event line has been held low. The total is summed over any number of separate low pulses, not measured per pulse. A free-running tick input marks the time base, and each tick that arrives while the synchronized line is low adds one count to an 8-bit accumulator. The accumulator stops at its ceiling instead of wrapping. Software reads the total through a small register port, and that read also empties it, so each read covers the time since the previous read.

The total is compared with a programmable limit at half the accumulator's resolution: one limit step equals two timer steps. When the total passes the limit, a sticky status bit is set and an active-low open-drain alert is pulled low, unless the alert is masked. A limit of zero raises the status bit on the first low level of the line, before any tick has arrived.

The block can also pull the line low itself, once per temperature source whose drive-select bit is set. Low levels caused by other devices on the line are timed in the same way. A boost option forces every running fan duty to full scale while the line is low.

Top module: `therm_accum_timer`

## Requirements
- R1: After reset the control fields (enable, boost, drive select), the limit, the mask, the accumulator and the status bit are all zero. Neither `line_oe` nor `alert_oe` is active.
- R2: While the enable bit (control register address 0, bit 0) is 0, ticks leave the accumulator unchanged.
- R3: With enable set, each cycle where `tick` is 1 and the synchronized line is low adds one to the accumulator. The total carries across separate low pulses.
- R4: The accumulator saturates at 0xFF and does not wrap.
- R5: A read (`rd_en`) of address 3 returns the accumulator and clears it to zero in the next cycle. If a counting tick falls in the same cycle as the read, the accumulator becomes 1.
- R6: The status bit is set when the accumulator is greater than twice the limit (limit register address 1). This means a limit of 0x80 or more can never be exceeded.
- R7: With a limit of zero and enable set, the status bit is set one cycle after the synchronized line goes low, even with no tick.
- R8: The status bit (address 4, bit 0) stays set until a read of address 4 clears it. If the set condition is still true during that read, the bit stays set.
- R9: `alert_oe` (1 = pull the alert low) is active exactly when the status bit is set and the mask bit (address 2, bit 0) is 0. The mask never stops the status bit from being set.
- R10: `line_oe` (1 = pull the line low) is active when some `temp_over[i]` is 1 and drive-select bit i (address 0, bits 4:2) is 1. If the drive-select field is zero, the line is never driven.
- R11: Low levels on the line are timed whether the block or an external device caused them.
- R12: With boost (address 0, bit 1) set and the synchronized line low, every nonzero fan duty is output as 0xFF and zero duties stay zero. Otherwise duties pass through unchanged.
- R13: A change on `line_in` reaches the timing, compare and boost logic after two clock edges.
- R14: Writes to addresses 0 to 2 update the fields above. `rdata` shows the register selected by `addr` in the same cycle, and unused bits and addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base pulse, one count per cycle high |
| temp_over | input | 3 | Per-source temperature over-limit flags |
| line_in | input | 1 | Thermal-event line level from the pad, low = asserted |
| line_oe | output | 1 | Pull the event line low when 1 |
| alert_oe | output | 1 | Pull the alert line low when 1 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, triggers clear-on-read |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| fan_duty_in | input | 32 | Four 8-bit fan duties from the fan controller, fan 0 in the low byte |
| fan_duty_out | output | 32 | Fan duties after the boost override |

## Verification
The assertions assume that `wr_en` and `rd_en` are never both high in the same cycle. They also assume that `line_in` is a pad level which may change in any cycle, since the synchronizer takes care of it, and that `tick` is a one-cycle pulse that may also repeat back to back. The stimulus keeps to these rules by giving each register access its own cycle, holding the strobes low otherwise, and driving ticks at fixed periods or at random in a separate random phase. The pad is modelled as a wired-low line, combining the external pull and `line_oe`, so that the block's own drive is fed back as a real bidirectional pin would do.

// File: rtl/tet_pkg.sv
package tet_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned NUM_SRC = 3;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_LIMIT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_MASK   = 3'd2;
    localparam logic [ADDR_W-1:0] A_TIMER  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

    typedef struct packed {
        logic [NUM_SRC-1:0] drv_sel;
        logic               boost;
        logic               enable;
        logic [DATA_W-1:0]  limit;
        logic               alert_mask;
    } cfg_t;
endpackage

// File: rtl/tet_sync.sv
module tet_sync #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];

    // R13: the output follows the input delayed by the chain length
    a_r13_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q[0] == $past(d) || $past(!rst_n));
endmodule

// File: rtl/tet_regs.sv
module tet_regs
    import tet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] acc,
    input  logic              status,
    output cfg_t              cfg,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_timer,
    output logic              rd_status
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    cfg_d.enable  = wdata[0];
                    cfg_d.boost   = wdata[1];
                    cfg_d.drv_sel = wdata[NUM_SRC+1:2];
                end
                A_LIMIT: cfg_d.limit      = wdata;
                A_MASK:  cfg_d.alert_mask = wdata[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata[NUM_SRC+1:0] = {cfg_q.drv_sel, cfg_q.boost, cfg_q.enable};
            A_LIMIT:  rdata = cfg_q.limit;
            A_MASK:   rdata[0] = cfg_q.alert_mask;
            A_TIMER:  rdata = acc;
            A_STATUS: rdata[0] = status;
            default:  rdata = '0;
        endcase
    end

    assign rd_timer  = rd_en && (addr == A_TIMER);
    assign rd_status = rd_en && (addr == A_STATUS);
    assign cfg       = cfg_q;

    // R14: a limit write lands in the next cycle
    a_r14_limit_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_LIMIT |=> cfg_q.limit == $past(wdata));
    // R14: the limit holds when no write targets it
    a_r14_limit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_LIMIT) |=> $stable(cfg_q.limit));
endmodule

// File: rtl/tet_accum.sv
module tet_accum #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         asserted,
    input  logic         enable,
    input  logic [W-1:0] limit,
    input  logic         clr_acc,
    input  logic         clr_status,
    output logic [W-1:0] acc,
    output logic         status
);
    localparam logic [W-1:0] SAT = '1;

    typedef struct packed {
        logic [W-1:0] acc;
        logic         status;
    } st_t;

    st_t  st_d, st_q;
    logic inc, exceed;

    always_comb begin
        inc    = tick && asserted && enable;
        exceed = ({1'b0, st_q.acc} > {limit, 1'b0})
              || (enable && asserted && limit == '0);
        st_d = st_q;
        if (clr_acc)
            st_d.acc = inc ? W'(1) : '0;
        else if (inc && st_q.acc != SAT)
            st_d.acc = st_q.acc + 1'b1;
        st_d.status = exceed || (st_q.status && !clr_status);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc    = st_q.acc;
    assign status = st_q.status;

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.acc == SAT && !clr_acc |=> st_q.acc == SAT);
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_acc |=> (st_q.acc == $past(st_q.acc) || st_q.acc == $past(st_q.acc) + 1'b1));
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable && !clr_acc |=> $stable(st_q.acc));
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_acc && !tick |=> st_q.acc == '0);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.status && !clr_status |=> st_q.status);
    a_r7_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
        enable && asserted && limit == '0 |=> st_q.status);
endmodule

// File: rtl/tet_fanboost.sv
module tet_fanboost #(
    parameter int unsigned NFAN = 4,
    parameter int unsigned W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boost,
    input  logic              asserted,
    input  logic [NFAN*W-1:0] duty_in,
    output logic [NFAN*W-1:0] duty_out
);
    logic force_on;
    assign force_on = boost && asserted;

    for (genvar i = 0; i < NFAN; i++) begin : g_fan
        logic [W-1:0] cur;
        logic         running;
        assign cur     = duty_in[i*W +: W];
        assign running = |cur;
        assign duty_out[i*W +: W] = (force_on && running) ? {W{1'b1}} : cur;

        a_r12_stopped_stays: assert property (@(posedge clk) disable iff (!rst_n)
            cur == '0 |-> duty_out[i*W +: W] == '0);
        a_r12_idle_passes: assert property (@(posedge clk) disable iff (!rst_n)
            !boost |-> duty_out[i*W +: W] == cur);
    end
endmodule

// File: rtl/therm_accum_timer.sv
module therm_accum_timer
    import tet_pkg::*;
#(
    parameter int unsigned NFAN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic [NUM_SRC-1:0]       temp_over,
    input  logic                     line_in,
    output logic                     line_oe,
    output logic                     alert_oe,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic [NFAN*DATA_W-1:0]   fan_duty_in,
    output logic [NFAN*DATA_W-1:0]   fan_duty_out
);
    cfg_t              cfg;
    logic              line_s, asserted;
    logic              rd_timer, rd_status;
    logic [DATA_W-1:0] acc;
    logic              status;

    tet_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_s)
    );
    assign asserted = !line_s;

    tet_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .acc(acc), .status(status), .cfg(cfg), .rdata(rdata),
        .rd_timer(rd_timer), .rd_status(rd_status)
    );

    tet_accum #(.W(DATA_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .tick(tick), .asserted(asserted),
        .enable(cfg.enable), .limit(cfg.limit), .clr_acc(rd_timer),
        .clr_status(rd_status), .acc(acc), .status(status)
    );

    tet_fanboost #(.NFAN(NFAN), .W(DATA_W)) u_boost (
        .clk(clk), .rst_n(rst_n), .boost(cfg.boost), .asserted(asserted),
        .duty_in(fan_duty_in), .duty_out(fan_duty_out)
    );

    assign line_oe  = |(temp_over & cfg.drv_sel);
    assign alert_oe = status && !cfg.alert_mask;

    a_r10_quiet_pin: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.drv_sel == '0 |-> !line_oe);
    a_r9_alert_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        alert_oe |-> status);
    a_r9_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.alert_mask |-> !alert_oe);
    a_r11_own_drive_seen: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe && $stable(line_oe) |=> !line_s || !$past(line_oe, 1) || $past(line_in));
endmodule

// File: tb/tb_therm_accum_timer.sv
`timescale 1ns/1ps
module tb_therm_accum_timer;
    import tet_pkg::*;
    localparam int NF = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [2:0]        temp_over = '0;
    logic              line_in, line_oe, alert_oe;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]        addr = 3'd3;
    logic [7:0]        wdata = '0;
    logic [7:0]        rdata;
    logic [NF*8-1:0]   fan_duty_in;
    logic [NF*8-1:0]   fan_duty_out;
    logic              ext_pull = 1'b0;
    int                fan[NF];

    assign line_in = !(ext_pull || line_oe);
    always_comb for (int i = 0; i < NF; i++) fan_duty_in[i*8 +: 8] = fan[i][7:0];

    therm_accum_timer #(.NFAN(NF)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .temp_over(temp_over),
        .line_in(line_in), .line_oe(line_oe), .alert_oe(alert_oe),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .fan_duty_in(fan_duty_in), .fan_duty_out(fan_duty_out)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    string tag = "R14";
    int tick_per = 0, tick_cnt = 0;
    bit rnd_tick = 0;
    int m_s1, m_s2, m_acc, m_stat, m_en, m_boost, m_drv, m_lim, m_mask;

    task automatic chk(string t, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata();
        case (addr)
            3'd0: return (m_drv << 2) | (m_boost << 1) | m_en;
            3'd1: return m_lim;
            3'd2: return m_mask;
            3'd3: return m_acc;
            3'd4: return m_stat;
            default: return 0;
        endcase
    endfunction

    task automatic step();
        int asrt, e_oe, inc, exc, rdt, rds, pad;
        if (rnd_tick) tick = 1'($urandom_range(0, 1));
        else tick = (tick_per > 0) && (tick_cnt % tick_per == 0);
        tick_cnt++;
        #1;
        asrt = (m_s2 == 0);
        e_oe = ((int'(temp_over) & m_drv) != 0);
        chk({tag, " rdata"}, rdata, exp_rdata());
        chk("R10 line_oe", line_oe, e_oe);
        chk("R9 alert_oe", alert_oe, m_stat && !m_mask);
        for (int i = 0; i < NF; i++)
            chk("R12 fan duty", fan_duty_out[i*8 +: 8],
                (m_boost && asrt && fan[i] != 0) ? 255 : fan[i]);
        @(posedge clk);
        pad  = !(ext_pull || e_oe);
        inc  = tick && asrt && m_en;
        exc  = (m_acc > 2 * m_lim) || (m_en && asrt && m_lim == 0);
        rdt  = rd_en && addr == 3'd3;
        rds  = rd_en && addr == 3'd4;
        if (rdt) m_acc = inc;
        else if (inc && m_acc < 255) m_acc++;
        m_stat = exc || (m_stat && !rds);
        if (wr_en) begin
            case (addr)
                3'd0: begin m_en = wdata[0]; m_boost = wdata[1]; m_drv = int'(wdata[4:2]); end
                3'd1: m_lim = wdata;
                3'd2: m_mask = wdata[0];
                default: ;
            endcase
        end
        m_s2 = m_s1;
        m_s1 = pad;
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(int a, int d);
        wr_en = 1; addr = 3'(a); wdata = 8'(d);
        step();
        wr_en = 0; addr = 3'd3;
    endtask

    task automatic rd(int a, string t);
        string keep;
        keep = tag; tag = t;
        rd_en = 1; addr = 3'(a);
        step();
        rd_en = 0; addr = 3'd3; tag = keep;
    endtask

    task automatic pulses(int n, int hi, int lo);
        for (int k = 0; k < n; k++) begin
            ext_pull = 1; run(hi);
            ext_pull = 0; run(lo);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NF; i++) fan[i] = 0;
        m_s1 = 1; m_s2 = 1; m_acc = 0; m_stat = 0; m_en = 0;
        m_boost = 0; m_drv = 0; m_lim = 0; m_mask = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values, R14 read map
        tag = "R1";
        for (int a = 0; a < 8; a++) begin addr = 3'(a); step(); end
        addr = 3'd3;

        // R2 disabled: ticks and a held line do nothing
        tag = "R2"; tick_per = 1; ext_pull = 1; run(20); ext_pull = 0; run(3);
        rd(3, "R2");

        // R3/R11 accumulate over separate external pulses
        tag = "R14"; wr(1, 8'h7F); wr(0, 1);
        tag = "R3"; tick_per = 2; pulses(3, 10, 6);
        rd(3, "R3"); rd(3, "R3"); rd(4, "R8");

        // R13 synchroniser latency with short pulses
        tag = "R13"; tick_per = 1; pulses(4, 1, 3); pulses(2, 2, 2);
        rd(3, "R13");

        // R4 saturation, R5 same-cycle tick on read
        tag = "R4"; ext_pull = 1; run(300);
        rd(3, "R4"); tag = "R5"; run(2); rd(3, "R5"); rd(3, "R5");
        ext_pull = 0; run(3); rd(3, "R5"); rd(4, "R8"); rd(4, "R8");

        // R6 compare at half resolution, R8 sticky, R9 alert
        tag = "R6"; wr(1, 3); tick_per = 3; pulses(4, 8, 4); run(5);
        rd(4, "R8"); rd(3, "R6"); rd(4, "R8"); run(2);
        tag = "R9"; wr(2, 1); pulses(4, 8, 4); run(3);
        rd(4, "R9"); wr(2, 0); run(2); rd(3, "R9"); rd(4, "R9");

        // R7 zero limit fires without any tick
        tag = "R7"; tick_per = 0; wr(1, 0); rd(3, "R7"); rd(4, "R7"); run(3);
        ext_pull = 1; run(5); ext_pull = 0; run(4); rd(4, "R7"); rd(4, "R7");

        // R10/R11 bidirectional drive, own drive is timed
        tag = "R10"; wr(1, 8'h60); rd(3, "R10");
        temp_over = 3'b111; run(6);
        wr(0, (3'b010 << 2) | 1); tick_per = 2;
        temp_over = 3'b001; run(6);
        temp_over = 3'b010; tag = "R11"; run(12);
        temp_over = 3'b000; run(4); rd(3, "R11");

        // R12 boost on running fans only
        tag = "R12"; fan[0] = 0; fan[1] = 8'h40; fan[2] = 8'h80; fan[3] = 8'h10;
        wr(0, 3); ext_pull = 1; run(6); ext_pull = 0; run(4);
        wr(0, 1); ext_pull = 1; run(6); ext_pull = 0; run(4);

        // random mix
        tag = "R14"; rnd_tick = 1; wr(0, 8'h1F); wr(1, 8'h20);
        for (int k = 0; k < 600; k++) begin
            ext_pull  = 1'($urandom_range(0, 3) == 0);
            temp_over = 3'($urandom_range(0, 7));
            for (int i = 0; i < NF; i++) fan[i] = $urandom_range(0, 2) * 8'h30;
            case ($urandom_range(0, 15))
                0: rd(3, "R5");
                1: rd(4, "R8");
                2: wr(1, $urandom_range(0, 12));
                3: wr(2, $urandom_range(0, 1));
                4: wr(0, $urandom_range(0, 31));
                default: step();
            endcase
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule